// File: doc/BRIEF.md
# Single-Byte SPI Master

This block is an SPI master that moves exactly one 8-bit word per start command. It has no queue. Software, or a small sequencer, programs it through an 8-bit register file on a plain synchronous bus that has an address, a write strobe, a read strobe, write data and registered read data. A start command loads the transmit byte into the shifter. The shifter then makes eight serial clock periods, driving MOSI and capturing MISO in the same transfer. When it is done, the block stores the captured byte, marks it as ready and raises an interrupt line.

The mode register selects the following:
- the SCK idle level;
- which SCK edge captures data (the inverse sense of the usual phase bit);
- MSB-first or LSB-first order;
- an internal loopback from MOSI to the capture input;
- a port enable.

An 8-bit divisor sets the serial clock to the bus clock divided by 4*(divisor+1). The mode and divisor values are sampled only when a transfer starts.

Top module: `spi_byte_master`

## Requirements
- R1: The registers are byte addressed: 0 mode (bits 4..0, reads back with bits 7..5 zero), 1 receive data, 2 transmit data (reads back), 3 control (reads 0), 4 status, 5 reserved (reads 0, writes ignored), 6 divisor (reads back).
- R2: A write to address 3 with bit 0 set starts a transfer when the port enable (mode 0x08) is 1 and no transfer is in progress. Status 0x02 reads 1 for the whole transfer.
- R3: During a transfer SCK makes exactly 16 transitions. Consecutive transitions are 2*(divisor+1) bus clocks apart, and the first comes 2*(divisor+1) clocks after the accepting edge. SCK takes the level of mode bit 0x02 at start and ends there.
- R4: Mode bit 0x10 = 1 captures MISO on odd-numbered SCK transitions (leading edges) and moves MOSI on the even ones. 0x10 = 0 does the reverse, and the first bit is already on MOSI from the start.
- R5: Mode bit 0x04 = 0 sends and assembles MSB first. 0x04 = 1 does so LSB first.
- R6: With mode bit 0x01 = 1 the capture input is the block's own MOSI, so the received byte equals the transmit byte and MISO is ignored.
- R7: On the cycle of the 16th transition, the receive register is written, status 0x01 (ready) is set and the interrupt rises. Busy stays set for one more cycle, so the first status read there returns 0x03 and the next returns 0x01.
- R8: Reading address 1 clears ready and the interrupt. Reading the status does not clear them.
- R9: A start with the enable at 0, or during a transfer, is ignored: no SCK activity, no interrupt, and the running byte is unchanged.
- R10: Writing the mode, divisor or transmit register during a transfer does not alter that transfer's timing, levels or data. The new values are stored for the next start.
- R11: After a synchronous reset, all registers read 0 and SCK, MOSI and the interrupt are low.
- R12: MOSI is low whenever no transfer is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register byte address |
| bus_we | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (side effect on receive register) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after the strobe |
| irq | output | 1 | Byte-complete interrupt |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The bench sweeps all sixteen combinations of capture edge, bit order, idle level and loopback against several divisors and byte patterns. It acts as a slave that follows the programmed edge rule. Two kinds of fault show up in the MOSI stream it reassembles and in the received byte:
- A design that swaps the edge sense delivers a byte shifted by one bit.
- A design that ignores the bit order delivers it reversed.

The bench also measures every SCK half period, so an off-by-one in the divide-by-four shows as a wrong spacing. It reads the status right after the last edge to catch a busy flag that drops together with ready. It then fires a second start and rewrites the mode, divisor and transmit registers mid-transfer; a design that did not freeze its settings would restart, change its rate or send the new byte.

// File: rtl/spib_pkg.sv
`timescale 1ns/1ps
package spib_pkg;
  // byte addresses of the register file
  localparam int A_MODE = 0;
  localparam int A_RXD  = 1;
  localparam int A_TXD  = 2;
  localparam int A_CTRL = 3;
  localparam int A_STAT = 4;
  localparam int A_RSVD = 5;
  localparam int A_DIV  = 6;

  // packed so that bit positions match the mode register layout (0x10 .. 0x01)
  typedef struct packed {
    logic samp_lead;   // 0x10: capture on leading edge
    logic enable;      // 0x08: port enable
    logic lsb_first;   // 0x04: bit order
    logic cpol;        // 0x02: SCK idle level
    logic loopback;    // 0x01: internal MOSI->capture path
  } mode_t;

  localparam int MODE_W = $bits(mode_t);

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_RUN    = 2'd1,
    ST_FINISH = 2'd2
  } state_t;
endpackage

// File: rtl/spib_baud.sv
`timescale 1ns/1ps
module spib_baud #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  localparam int CW = DIV_W + 1;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] reload_q;
  logic [CW-1:0] reload_new;

  // half period of 2*(div+1) clocks -> count from 2*div+1 down to 0
  assign reload_new = {div_i, 1'b1};
  assign tick_o     = run_i && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      reload_q <= '0;
    end else if (load_i) begin
      cnt_q    <= reload_new;
      reload_q <= reload_new;
    end else if (run_i) begin
      if (cnt_q == '0) cnt_q <= reload_q;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  // R3: the countdown never leaves the window frozen at start
  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= reload_q);

  // R10: the frozen reload only changes on a start
  p_reload_frozen_r10: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> $stable(reload_q));
endmodule

// File: rtl/spib_engine.sv
`timescale 1ns/1ps
module spib_engine
  import spib_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_req_i,
  input  mode_t             mode_i,
  input  logic [DATA_W-1:0] tx_i,
  input  logic              miso_i,
  input  logic              tick_i,
  output logic              load_o,
  output logic              run_o,
  output logic              busy_o,
  output logic              sck_o,
  output logic              mosi_o,
  output logic              rx_set_o,
  output logic [DATA_W-1:0] rx_byte_o
);
  localparam int EDGES = 2 * DATA_W;
  localparam int EW    = $clog2(EDGES);
  localparam logic [EW-1:0] LAST_E = EW'(EDGES - 1);

  state_t            st_q;
  logic              s_lead_q, s_lsb_q, s_cpol_q, s_lb_q;
  logic [DATA_W-1:0] tsh_q, rsh_q;
  logic [EW-1:0]     ecnt_q;
  logic              sck_q, mosi_q;

  logic              accept, k_odd, last_e, samp_now, drive_now, din;
  logic [DATA_W-1:0] rsh_next, tsh_next;

  assign accept = start_req_i && mode_i.enable && (st_q == ST_IDLE);
  assign k_odd  = ~ecnt_q[0];              // transition number ecnt+1 is odd
  assign last_e = (ecnt_q == LAST_E);

  assign samp_now  = tick_i && (s_lead_q ? k_odd : !k_odd);
  assign drive_now = tick_i && !last_e &&
                     (s_lead_q ? !k_odd : (k_odd && (ecnt_q != '0)));

  assign din      = s_lb_q ? mosi_q : miso_i;
  assign rsh_next = s_lsb_q ? {din, rsh_q[DATA_W-1:1]} : {rsh_q[DATA_W-2:0], din};
  assign tsh_next = s_lsb_q ? (tsh_q >> 1) : (tsh_q << 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_IDLE;
      s_lead_q <= 1'b0;
      s_lsb_q  <= 1'b0;
      s_cpol_q <= 1'b0;
      s_lb_q   <= 1'b0;
      tsh_q    <= '0;
      rsh_q    <= '0;
      ecnt_q   <= '0;
      sck_q    <= 1'b0;
      mosi_q   <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (accept) begin
            s_lead_q <= mode_i.samp_lead;
            s_lsb_q  <= mode_i.lsb_first;
            s_cpol_q <= mode_i.cpol;
            s_lb_q   <= mode_i.loopback;
            tsh_q    <= tx_i;
            rsh_q    <= '0;
            ecnt_q   <= '0;
            sck_q    <= mode_i.cpol;
            mosi_q   <= mode_i.lsb_first ? tx_i[0] : tx_i[DATA_W-1];
            st_q     <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (tick_i) begin
            sck_q  <= ~sck_q;
            ecnt_q <= ecnt_q + 1'b1;
            if (samp_now) rsh_q <= rsh_next;
            if (drive_now) begin
              tsh_q  <= tsh_next;
              mosi_q <= s_lsb_q ? tsh_next[0] : tsh_next[DATA_W-1];
            end
            if (last_e) st_q <= ST_FINISH;
          end
        end
        ST_FINISH: begin
          mosi_q <= 1'b0;
          st_q   <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign load_o    = accept;
  assign run_o     = (st_q == ST_RUN);
  assign busy_o    = (st_q != ST_IDLE);
  assign sck_o     = sck_q;
  assign mosi_o    = mosi_q;
  assign rx_set_o  = (st_q == ST_RUN) && tick_i && last_e;
  assign rx_byte_o = samp_now ? rsh_next : rsh_q;

  // R3: between transfers SCK rests at the level frozen at the last start
  p_sck_idle_r3: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_IDLE) |-> (sck_q == s_cpol_q));

  // R12: no data on the line outside a transfer
  p_mosi_idle_r12: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_IDLE) |-> !mosi_q);

  // R7: busy outlives the completion by exactly one cycle
  p_busy_lag_r7: assert property (@(posedge clk) disable iff (rst)
    rx_set_o |=> (st_q == ST_FINISH) ##1 (st_q == ST_IDLE));

  // R9: a start with the port disabled leaves the engine idle
  p_disabled_start_r9: assert property (@(posedge clk) disable iff (rst)
    ((st_q == ST_IDLE) && start_req_i && !mode_i.enable) |=> (st_q == ST_IDLE));

  // R9: a start during a transfer does not reload the shifter or the count
  p_busy_start_r9: assert property (@(posedge clk) disable iff (rst)
    ((st_q == ST_RUN) && start_req_i && !tick_i) |=> ($stable(tsh_q) && $stable(ecnt_q)));

  // R10: the frozen settings stay put while the transfer runs
  p_frozen_mode_r10: assert property (@(posedge clk) disable iff (rst)
    ((st_q != ST_IDLE) && $past(st_q != ST_IDLE)) |-> ($stable(s_lead_q) && $stable(s_lsb_q) && $stable(s_cpol_q) && $stable(s_lb_q)));
endmodule

// File: rtl/spib_regfile.sv
`timescale 1ns/1ps
module spib_regfile
  import spib_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output mode_t             mode_o,
  output logic [DATA_W-1:0] tx_o,
  output logic [DIV_W-1:0]  div_o,
  output logic              start_req_o,
  input  logic              busy_i,
  input  logic              rx_set_i,
  input  logic [DATA_W-1:0] rx_byte_i,
  output logic              irq_o
);
  mode_t             mode_q;
  logic [DATA_W-1:0] tx_q, rx_q, rd_mux, rdata_q;
  logic [DIV_W-1:0]  div_q;
  logic              ready_q, irq_q;
  logic              hit_mode, hit_rxd, hit_txd, hit_ctrl, hit_div;

  assign hit_mode = (addr_i == ADDR_W'(A_MODE));
  assign hit_rxd  = (addr_i == ADDR_W'(A_RXD));
  assign hit_txd  = (addr_i == ADDR_W'(A_TXD));
  assign hit_ctrl = (addr_i == ADDR_W'(A_CTRL));
  assign hit_div  = (addr_i == ADDR_W'(A_DIV));

  assign start_req_o = we_i && hit_ctrl && wdata_i[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
      tx_q   <= '0;
      div_q  <= '0;
    end else if (we_i) begin
      if (hit_mode) mode_q <= mode_t'(wdata_i[MODE_W-1:0]);
      if (hit_txd)  tx_q   <= wdata_i;
      if (hit_div)  div_q  <= wdata_i[DIV_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_q    <= '0;
      ready_q <= 1'b0;
      irq_q   <= 1'b0;
    end else if (rx_set_i) begin
      rx_q    <= rx_byte_i;
      ready_q <= 1'b1;
      irq_q   <= 1'b1;
    end else if (rd_i && hit_rxd) begin
      ready_q <= 1'b0;
      irq_q   <= 1'b0;
    end
  end

  always_comb begin
    rd_mux = '0;
    unique case (int'(addr_i))
      A_MODE:  rd_mux = DATA_W'(mode_q);
      A_RXD:   rd_mux = rx_q;
      A_TXD:   rd_mux = tx_q;
      A_STAT:  rd_mux = DATA_W'({busy_i, ready_q});
      A_DIV:   rd_mux = DATA_W'(div_q);
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_mux;
  end

  assign rdata_o = rdata_q;
  assign mode_o  = mode_q;
  assign tx_o    = tx_q;
  assign div_o   = div_q;
  assign irq_o   = irq_q;

  // R7: completion writes the byte and raises ready and the interrupt together
  p_complete_r7: assert property (@(posedge clk) disable iff (rst)
    rx_set_i |=> (ready_q && irq_q && (rx_q == $past(rx_byte_i))));

  // R8: a receive-register read with no new byte clears ready and interrupt
  p_read_clears_r8: assert property (@(posedge clk) disable iff (rst)
    (rd_i && hit_rxd && !rx_set_i) |=> (!ready_q && !irq_q));

  // R8: status reads leave the flags alone
  p_stat_read_keeps_r8: assert property (@(posedge clk) disable iff (rst)
    (rd_i && (addr_i == ADDR_W'(A_STAT)) && !rx_set_i) |=> $stable(irq_q));
endmodule

// File: rtl/spi_byte_master.sv
`timescale 1ns/1ps
module spi_byte_master
  import spib_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  output logic              sck,
  output logic              mosi,
  input  logic              miso
);
  mode_t             mode;
  logic [DATA_W-1:0] tx_byte, rx_byte;
  logic [DIV_W-1:0]  div;
  logic              start_req, load, run, busy, tick, rx_set;

  initial begin
    if (DATA_W < MODE_W) $error("data width too narrow for the mode field");
  end

  spib_regfile #(
    .DATA_W(DATA_W), .DIV_W(DIV_W), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk        (clk),
    .rst        (rst),
    .addr_i     (bus_addr),
    .we_i       (bus_we),
    .rd_i       (bus_rd),
    .wdata_i    (bus_wdata),
    .rdata_o    (bus_rdata),
    .mode_o     (mode),
    .tx_o       (tx_byte),
    .div_o      (div),
    .start_req_o(start_req),
    .busy_i     (busy),
    .rx_set_i   (rx_set),
    .rx_byte_i  (rx_byte),
    .irq_o      (irq)
  );

  spib_baud #(.DIV_W(DIV_W)) u_baud (
    .clk    (clk),
    .rst    (rst),
    .load_i (load),
    .run_i  (run),
    .div_i  (div),
    .tick_o (tick)
  );

  spib_engine #(.DATA_W(DATA_W)) u_eng (
    .clk        (clk),
    .rst        (rst),
    .start_req_i(start_req),
    .mode_i     (mode),
    .tx_i       (tx_byte),
    .miso_i     (miso),
    .tick_i     (tick),
    .load_o     (load),
    .run_o      (run),
    .busy_o     (busy),
    .sck_o      (sck),
    .mosi_o     (mosi),
    .rx_set_o   (rx_set),
    .rx_byte_o  (rx_byte)
  );

  // R2: an accepted start makes the block busy on the next cycle
  p_start_busy_r2: assert property (@(posedge clk) disable iff (rst)
    (start_req && mode.enable && !busy) |=> busy);

  // R3: SCK moves only on divider ticks
  p_sck_on_tick_r3: assert property (@(posedge clk) disable iff (rst)
    (run && !tick) |=> $stable(sck));
endmodule

// File: tb/sim_spi_byte_master.sv
`timescale 1ns/1ps
module sim_spi_byte_master;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] addr = '0;
  logic       we = 1'b0, rd = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq, sck, mosi;
  logic       miso = 1'b0;

  int  checks = 0;
  int  fails  = 0;
  bit  finished = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  spi_byte_master u0 (
    .clk(clk), .rst(rst), .bus_addr(addr), .bus_we(we), .bus_rd(rd),
    .bus_wdata(wdata), .bus_rdata(rdata), .irq(irq), .sck(sck),
    .mosi(mosi), .miso(miso)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // all bus tasks are entered at a falling edge and return at one
  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rdr(input logic [2:0] a, output logic [7:0] d);
    addr = a; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    d = rdata;
  endtask

  task automatic xfer(input logic [7:0] m, input logic [7:0] dv, input logic [7:0] tx,
                      input logic [7:0] sb, input bit disturb);
    bit         lead, lsb, cp, lb, per_ok, prev;
    logic [7:0] mb, d, expv;
    int         si, pre, hp, c;
    lead = m[4]; lsb = m[2]; cp = m[1]; lb = m[0];
    mb = '0; si = 0; pre = 0; per_ok = 1'b1;
    hp = 2 * (int'(dv) + 1);
    wr(3'd0, m); wr(3'd6, dv); wr(3'd2, tx);
    if (lead) miso = lsb ? sb[0] : sb[7];
    wr(3'd3, 8'h01);
    chk(sck == cp, "R3 sck level at start", sck, cp);
    for (int k = 1; k <= 16; k++) begin
      c = pre; pre = 0; prev = sck;
      while (sck == prev && c < 3000) begin
        @(negedge clk);
        c++;
      end
      if (c != hp) per_ok = 1'b0;
      if (lead ? (k % 2 == 1) : (k % 2 == 0)) begin
        if (lsb) mb[si] = mosi; else mb[7-si] = mosi;
        si++;
      end else if (k < 16) begin
        int j = lead ? k / 2 : (k - 1) / 2;
        miso = lsb ? sb[j] : sb[7-j];
      end
      if (disturb && k == 4) begin
        wr(3'd2, ~tx); wr(3'd3, 8'h01); wr(3'd0, m ^ 8'h16); wr(3'd6, dv + 8'd5);
        pre = 4;
      end
    end
    chk(per_ok, disturb ? "R10 half period kept" : "R3 half period", per_ok, 1);
    chk(irq == 1'b1, "R7 irq on last edge", irq, 1);
    rdr(3'd4, d); chk(d == 8'h03, "R7 busy still set with ready", d, 8'h03);
    rdr(3'd4, d); chk(d == 8'h01, "R7 busy cleared next cycle", d, 8'h01);
    chk(sck == cp, disturb ? "R10 sck ends at old idle" : "R3 sck ends at idle", sck, cp);
    chk(mosi == 1'b0, "R12 mosi low after transfer", mosi, 0);
    chk(mb == tx, disturb ? "R9 running byte unchanged" : "R4 R5 mosi stream", mb, tx);
    expv = lb ? tx : sb;
    rdr(3'd1, d);
    chk(d == expv, lb ? "R6 loopback capture" : "R4 R5 miso capture", d, expv);
    chk(irq == 1'b0, "R8 irq cleared by rx read", irq, 0);
    rdr(3'd4, d); chk(d == 8'h00, "R8 ready cleared", d, 0);
  endtask

  initial begin
    logic [7:0] d, m, tx, sb, s0;
    bit stay;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R11 reset state
    chk(sck == 1'b0 && mosi == 1'b0 && irq == 1'b0, "R11 lines low", {sck, mosi, irq}, 0);
    for (int a = 0; a < 8; a++) begin
      rdr(3'(a), d);
      chk(d == 8'h00, "R11 register zero", d, 0);
    end

    // R1 register map
    wr(3'd0, 8'hFF); rdr(3'd0, d); chk(d == 8'h1F, "R1 mode readback", d, 8'h1F);
    wr(3'd2, 8'h5A); rdr(3'd2, d); chk(d == 8'h5A, "R1 tx readback", d, 8'h5A);
    wr(3'd6, 8'hC4); rdr(3'd6, d); chk(d == 8'hC4, "R1 divisor readback", d, 8'hC4);
    wr(3'd5, 8'hFF); rdr(3'd5, d); chk(d == 8'h00, "R1 reserved reads zero", d, 0);
    wr(3'd3, 8'hFE); rdr(3'd3, d); chk(d == 8'h00, "R1 control reads zero", d, 0);
    rdr(3'd4, d); chk(d == 8'h00, "R2 no start without bit0", d, 0);

    // R9 start with enable cleared
    wr(3'd0, 8'h12); s0 = {7'd0, sck};
    wr(3'd3, 8'h01);
    stay = 1'b1;
    for (int i = 0; i < 40; i++) begin
      if (sck != s0[0] || mosi != 1'b0 || irq != 1'b0) stay = 1'b0;
      @(negedge clk);
    end
    chk(stay, "R9 disabled start ignored lines", stay, 1);
    rdr(3'd4, d); chk(d == 8'h00, "R9 disabled start status", d, 0);

    // sweep of mode combinations, divisors and patterns
    for (int mi = 0; mi < 16; mi++) begin
      m = {3'b000, mi[3], 1'b1, mi[2], mi[1], mi[0]};
      for (int dvi = 0; dvi < 2; dvi++) begin
        for (int p = 0; p < 4; p++) begin
          if (p == 3) begin
            tx = 8'h01; sb = 8'h80;
          end else begin
            tx = 8'hA5 ^ 8'(mi * 29) ^ 8'(p * 71) ^ 8'(dvi * 13);
            sb = {tx[3:0], tx[7:4]} ^ 8'h5C;
          end
          xfer(m, (dvi == 0) ? 8'd0 : 8'd2, tx, sb, 1'b0);
        end
      end
    end

    // R3 largest divisor
    xfer(8'h1A, 8'd255, 8'hC3, 8'h3E, 1'b0);

    // R9 R10 disturbance during a transfer
    m = 8'h08;
    xfer(m, 8'd3, 8'h6D, 8'hB2, 1'b1);
    stay = 1'b1;
    for (int i = 0; i < 100; i++) begin
      if (irq != 1'b0 || sck != 1'b0) stay = 1'b0;
      @(negedge clk);
    end
    chk(stay, "R9 busy start not replayed", stay, 1);
    rdr(3'd0, d); chk(d == (m ^ 8'h16), "R10 mode stored for next", d, m ^ 8'h16);
    rdr(3'd6, d); chk(d == 8'd8, "R10 divisor stored for next", d, 8);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule